// File: doc/BRIEF.md
# Oversampling UART Receiver with Address-Bit Frames

This block turns an asynchronous serial line into parallel characters. An enable pulse at eight times the baud rate paces it, so each bit period holds eight sub-samples. A falling line must stay low for four consecutive sub-samples before the block accepts a start bit. Each later bit is then decided by a two-of-three vote over the sub-samples in the middle of that bit. The character length is configurable from five to eight bits, sent least significant bit first.

In address-bit mode one extra flag bit follows the last data bit and comes before the stop bit. The receiver of a multidrop bus uses this flag to tell address characters from data characters. The block reports the flag beside the byte. It looks for a new start bit only once the stop bit has been voted. A low address bit followed by a slowly rising stop bit therefore cannot count as four low sub-samples and open a false frame. A stop bit voted low is reported as a framing error. An all-zero frame with a low stop bit is reported as a break. After any framing error the block waits for the line to go high before it looks for a new start bit.

Top module: `uart_addr_rx`

## Requirements
- R1: After reset, rx_valid, rx_data, rx_addr_flag, rx_frame_err and rx_break are all 0, and the line input is taken as idle-high.
- R2: A start bit is accepted only after 4 consecutive low sub-samples of the synchronised line. A low pulse of 3 sub-samples or fewer returns the block to idle, gives no rx_valid, and does not disturb the next frame.
- R3: Number the sub-samples of a bit 1 to 8, where sub-sample 1 of the start bit is its first low sub-sample. The value of each data, flag and stop bit is the majority of its sub-samples 4, 5 and 6. A single disturbed sub-sample inside that window, or any disturbance in sub-samples 1, 2, 3, 7 and 8, does not change the value.
- R4: cfg_char_len selects the data bit count: 0 gives 5, 1 gives 6, 2 gives 7, 3 gives 8. Bits arrive least significant first. rx_data holds them right-justified, with unused upper bits 0.
- R5: When cfg_addr_mode is 1, one flag bit is received after the last data bit and before the stop bit, and its value appears on rx_addr_flag. When cfg_addr_mode is 0, no flag bit is expected and rx_addr_flag is 0. Both configuration inputs are captured when a start bit is accepted.
- R6: Start-bit search resumes only after sub-sample 6 of the stop bit. Low sub-samples in the flag bit and in the early part of a stop bit that votes high do not open a new frame.
- R7: rx_valid is a one-cycle pulse on the clock after the tick that carries sub-sample 6 of the stop bit. rx_data, rx_addr_flag, rx_frame_err and rx_break change only together with that pulse and hold until the next one.
- R8: A stop bit voted low gives rx_frame_err = 1 with the pulse. The block then accepts no start bit until it sees a high sub-sample.
- R9: rx_break is 1 when the stop bit votes low, every data bit votes 0 and no flag bit of 1 was received. It implies rx_frame_err = 1.
- R10: The line is sampled only on clock cycles with tick_8x high. Without ticks the block does not advance, and rx_valid rises only on the clock after a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_8x | input | 1 | One-cycle enable at eight times the baud rate |
| rxd_in | input | 1 | Serial line, idle high, asynchronous |
| cfg_char_len | input | 2 | Data bit count minus five |
| cfg_addr_mode | input | 1 | 1 expects a flag bit before the stop bit |
| rx_data | output | 8 | Received character, right-justified |
| rx_addr_flag | output | 1 | Flag bit of the last frame |
| rx_valid | output | 1 | One-cycle result strobe |
| rx_frame_err | output | 1 | Stop bit of the last frame voted low |
| rx_break | output | 1 | Last frame was a break |

## Verification
The line passes a two-stage synchroniser. The bench changes rxd_in just after a tick edge, and ticks come every four clocks, so each level it drives is the sub-sample taken at the next tick. Results are due in the clock after the tick carrying sub-sample 6 of the stop bit. The bench counts ticks from the start bit and checks rx_valid low one tick earlier, high just after that edge, and low again one clock later. For the quiet outcomes (glitches, slow-rising stop bits, line held low after a framing error, ticks stopped) it waits 100 tick periods, longer than any false frame would take, and confirms that no extra rx_valid pulse came.

// File: rtl/uart_addr_rx_pkg.sv
package uart_addr_rx_pkg;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_FLAG,
        RX_STOP,
        RX_HOLD
    } rx_state_e;

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/uart_addr_rx_sync.sv
module uart_addr_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= {sh_q[STAGES-2:0], d};
    end

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/uart_addr_rx_vote.sv
module uart_addr_rx_vote #(
    parameter int SUB_W = 3,
    parameter int FIRST = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [SUB_W-1:0] sub,
    input  logic             din,
    output logic             vote
);
    import uart_addr_rx_pkg::*;

    logic [1:0] smp_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_q <= '1;
        end else if (en) begin
            if (sub == SUB_W'(FIRST))     smp_q[0] <= din;
            if (sub == SUB_W'(FIRST + 1)) smp_q[1] <= din;
        end
    end

    // third sample is the live line at the last window position
    assign vote = maj3(smp_q[0], smp_q[1], din);
endmodule

// File: rtl/uart_addr_rx.sv
module uart_addr_rx #(
    parameter int OSR         = 8,
    parameter int START_LOWS  = 4,
    parameter int MIN_BITS    = 5,
    parameter int MAX_BITS    = 8,
    parameter int LEN_W       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_8x,
    input  logic                rxd_in,
    input  logic [LEN_W-1:0]    cfg_char_len,
    input  logic                cfg_addr_mode,
    output logic [MAX_BITS-1:0] rx_data,
    output logic                rx_addr_flag,
    output logic                rx_valid,
    output logic                rx_frame_err,
    output logic                rx_break
);
    import uart_addr_rx_pkg::*;

    localparam int SUB_W      = $clog2(OSR);
    localparam int LOW_W      = $clog2(START_LOWS + 1);
    localparam int IDX_W      = $clog2(MAX_BITS);
    localparam int VOTE_FIRST = OSR / 2 - 1;
    localparam int VOTE_AT    = OSR / 2 + 1;
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OSR - 1);
    localparam logic [SUB_W-1:0] SUB_VOTE = SUB_W'(VOTE_AT);

    typedef struct packed {
        rx_state_e           st;
        logic [SUB_W-1:0]    sub;
        logic [LOW_W-1:0]    lows;
        logic [IDX_W-1:0]    idx;
        logic [IDX_W-1:0]    last;
        logic                amode;
        logic                fbit;
        logic [MAX_BITS-1:0] shreg;
        logic [MAX_BITS-1:0] data;
        logic                aflag;
        logic                valid;
        logic                ferr;
        logic                brk;
    } rx_regs_t;

    rx_regs_t r_d, r_q;
    logic     rx_s;
    logic     vote;

    uart_addr_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (rxd_in),
        .q     (rx_s)
    );

    uart_addr_rx_vote #(.SUB_W(SUB_W), .FIRST(VOTE_FIRST)) u_vote (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (tick_8x),
        .sub   (r_q.sub),
        .din   (rx_s),
        .vote  (vote)
    );

    always_comb begin
        r_d       = r_q;
        r_d.valid = 1'b0;
        if (tick_8x) begin
            unique case (r_q.st)
                RX_IDLE: begin
                    if (rx_s) begin
                        r_d.lows = '0;
                    end else if (r_q.lows == LOW_W'(START_LOWS - 1)) begin
                        r_d.st    = RX_START;
                        r_d.sub   = SUB_W'(START_LOWS);
                        r_d.lows  = '0;
                        r_d.idx   = '0;
                        r_d.last  = IDX_W'(MIN_BITS - 1) + IDX_W'(cfg_char_len);
                        r_d.amode = cfg_addr_mode;
                        r_d.fbit  = 1'b0;
                        r_d.shreg = '0;
                    end else begin
                        r_d.lows = r_q.lows + LOW_W'(1);
                    end
                end
                RX_START: begin
                    r_d.sub = r_q.sub + SUB_W'(1);
                    if (r_q.sub == SUB_LAST) begin
                        r_d.sub = '0;
                        r_d.st  = RX_DATA;
                    end
                end
                RX_DATA: begin
                    r_d.sub = r_q.sub + SUB_W'(1);
                    if (r_q.sub == SUB_VOTE) r_d.shreg[r_q.idx] = vote;
                    if (r_q.sub == SUB_LAST) begin
                        r_d.sub = '0;
                        if (r_q.idx == r_q.last) r_d.st = r_q.amode ? RX_FLAG : RX_STOP;
                        else                     r_d.idx = r_q.idx + IDX_W'(1);
                    end
                end
                RX_FLAG: begin
                    r_d.sub = r_q.sub + SUB_W'(1);
                    if (r_q.sub == SUB_VOTE) r_d.fbit = vote;
                    if (r_q.sub == SUB_LAST) begin
                        r_d.sub = '0;
                        r_d.st  = RX_STOP;
                    end
                end
                RX_STOP: begin
                    r_d.sub = r_q.sub + SUB_W'(1);
                    if (r_q.sub == SUB_VOTE) begin
                        r_d.data  = r_q.shreg;
                        r_d.aflag = r_q.amode & r_q.fbit;
                        r_d.valid = 1'b1;
                        r_d.ferr  = ~vote;
                        r_d.brk   = ~vote & (r_q.shreg == '0) & ~(r_q.amode & r_q.fbit);
                        r_d.sub   = '0;
                        r_d.lows  = '0;
                        r_d.st    = vote ? RX_IDLE : RX_HOLD;
                    end
                end
                RX_HOLD: begin
                    if (rx_s) r_d.st = RX_IDLE;
                end
                default: r_d.st = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rx_data      = r_q.data;
    assign rx_addr_flag = r_q.aflag;
    assign rx_valid     = r_q.valid;
    assign rx_frame_err = r_q.ferr;
    assign rx_break     = r_q.brk;
endmodule

// File: rtl/uart_addr_rx_chk.sv
module uart_addr_rx_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tick_8x,
    input logic [DW-1:0] rx_data,
    input logic          rx_addr_flag,
    input logic          rx_valid,
    input logic          rx_frame_err,
    input logic          rx_break
);
    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R7

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |-> ($stable(rx_data) && $stable(rx_addr_flag)
                       && $stable(rx_frame_err) && $stable(rx_break))); // R7

    AST_VALID_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(tick_8x)); // R10

    AST_BREAK_HAS_FERR: assert property (@(posedge clk) disable iff (!rst_n)
        rx_break |-> rx_frame_err); // R9

    AST_BREAK_ALL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rx_break |-> (rx_data == '0 && !rx_addr_flag)); // R9
endmodule

bind uart_addr_rx uart_addr_rx_chk #(.DW(MAX_BITS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_8x      (tick_8x),
    .rx_data      (rx_data),
    .rx_addr_flag (rx_addr_flag),
    .rx_valid     (rx_valid),
    .rx_frame_err (rx_frame_err),
    .rx_break     (rx_break)
);

// File: tb/uart_addr_rx_bench.sv
module uart_addr_rx_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       tick_en = 1'b1;
    logic [1:0] tdiv = '0;
    logic       rxd = 1'b1;
    logic [1:0] cfg_len = 2'd3;
    logic       cfg_am = 1'b0;
    logic [7:0] rx_data;
    logic       rx_addr_flag, rx_valid, rx_frame_err, rx_break;
    int         n_chk = 0, n_err = 0, vcnt = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    always @(negedge clk) begin
        if (tick_en) tdiv <= tdiv + 2'd1;
        tick <= tick_en && (tdiv == 2'd3);
    end

    always @(posedge clk) if (rst_n && rx_valid) vcnt <= vcnt + 1;

    uart_addr_rx u_uart_addr_rx (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick_8x       (tick),
        .rxd_in        (rxd),
        .cfg_char_len  (cfg_len),
        .cfg_addr_mode (cfg_am),
        .rx_data       (rx_data),
        .rx_addr_flag  (rx_addr_flag),
        .rx_valid      (rx_valid),
        .rx_frame_err  (rx_frame_err),
        .rx_break      (rx_break)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wait_tick();
        @(posedge clk);
        while (!tick) @(posedge clk);
        #1;
    endtask

    task automatic wait_ticks(input int n);
        for (int i = 0; i < n; i++) wait_tick();
    endtask

    function automatic logic vote3(input logic v, input logic [7:0] f);
        logic a, b, c;
        a = v ^ f[3]; b = v ^ f[4]; c = v ^ f[5];
        return (a & b) | (a & c) | (b & c);
    endfunction

    task automatic drive_bit(input logic v, input logic [7:0] f);
        for (int s = 0; s < 8; s++) begin
            rxd = v ^ f[s];
            wait_tick();
        end
    endtask

    task automatic send_frame(input string req, input int code, input logic am,
                              input logic [7:0] d, input logic ab, input logic sv,
                              input logic [7:0] sf, input logic rnd, input logic [7:0] df);
        int         n = code + 5;
        int         v0;
        logic [7:0] exp_d = '0;
        logic [7:0] f;
        logic       ef, ea, eb;
        cfg_len = 2'(code);
        cfg_am  = am;
        wait_tick();
        v0 = vcnt;
        drive_bit(1'b0, 8'h00);
        for (int i = 0; i < n; i++) begin
            f = rnd ? ((8'($urandom) & 8'hC7) | (8'd1 << (3 + $urandom % 3))) : df;
            exp_d[i] = vote3(d[i], f);
            drive_bit(d[i], f);
        end
        if (am) drive_bit(ab, 8'h00);
        for (int s = 0; s < 6; s++) begin
            rxd = sv ^ sf[s];
            if (s == 5) chk(req, "R7 no strobe before stop sample 6", int'(rx_valid), 0);
            wait_tick();
        end
        ef = ~vote3(sv, sf);
        ea = am & ab;
        eb = ef & (exp_d == 8'h00) & ~ea;
        chk(req, "R7 strobe", int'(rx_valid), 1);
        chk(req, "data", int'(rx_data), int'(exp_d));
        chk(req, "R5 flag", int'(rx_addr_flag), int'(ea));
        chk(req, "R8 frame err", int'(rx_frame_err), int'(ef));
        chk(req, "R9 break", int'(rx_break), int'(eb));
        rxd = sv;
        @(posedge clk); #1;
        chk(req, "R7 strobe one cycle", int'(rx_valid), 0);
        chk(req, "R7 one strobe per frame", vcnt - v0, 1);
    endtask

    initial begin
        int v0;
        void'($urandom(32'd20240611));
        #23 rst_n = 1'b1;
        #2;
        chk("R1", "valid", int'(rx_valid), 0);
        chk("R1", "data", int'(rx_data), 0);
        chk("R1", "flags", int'({rx_addr_flag, rx_frame_err, rx_break}), 0);
        wait_ticks(20);
        chk("R1", "no frame from idle line", vcnt, 0);

        send_frame("R4 8b", 3, 1'b0, 8'hA5, 1'b0, 1'b1, 8'h00, 1'b0, 8'h00);
        for (int c = 0; c < 4; c++)
            send_frame("R4 len", c, 1'b0, 8'hFF, 1'b1, 1'b1, 8'h00, 1'b0, 8'h00);
        send_frame("R5 flag set", 3, 1'b1, 8'h3C, 1'b1, 1'b1, 8'h00, 1'b0, 8'h00);
        send_frame("R5 flag clear", 1, 1'b1, 8'h15, 1'b0, 1'b1, 8'h00, 1'b0, 8'h00);
        send_frame("R3 window flip", 3, 1'b0, 8'h96, 1'b0, 1'b1, 8'h10, 1'b0, 8'h08);
        send_frame("R3 edge flips", 3, 1'b0, 8'h00, 1'b0, 1'b1, 8'hC7, 1'b0, 8'hC7);
        send_frame("R3 stop flip", 2, 1'b0, 8'h55, 1'b0, 1'b1, 8'h20, 1'b0, 8'h00);

        // R6: low flag bit, stop rises late (sub-samples 1..3 low)
        send_frame("R6 slow stop", 3, 1'b1, 8'h0F, 1'b0, 1'b1, 8'h07, 1'b0, 8'h00);
        v0 = vcnt;
        wait_ticks(100);
        chk("R6", "no false start after slow stop", vcnt - v0, 0);

        // R2: three low sub-samples only
        wait_tick();
        v0 = vcnt;
        rxd = 1'b0; wait_ticks(3);
        rxd = 1'b1; wait_ticks(100);
        chk("R2", "short glitch ignored", vcnt - v0, 0);
        send_frame("R2 frame after glitch", 3, 1'b0, 8'h81, 1'b0, 1'b1, 8'h00, 1'b0, 8'h00);

        // R9 and R8: break, then line held low
        send_frame("R9 break", 3, 1'b1, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00);
        v0 = vcnt;
        rxd = 1'b0; wait_ticks(100);
        chk("R8", "no start while line stays low", vcnt - v0, 0);
        rxd = 1'b1; wait_ticks(2);
        send_frame("R8 recover", 3, 1'b0, 8'h42, 1'b0, 1'b1, 8'h00, 1'b0, 8'h00);
        send_frame("R8 ferr", 3, 1'b0, 8'h33, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00);
        rxd = 1'b1; wait_ticks(2);
        send_frame("R9 flag blocks break", 3, 1'b1, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00);
        rxd = 1'b1; wait_ticks(2);

        // R10: no ticks, line low for a long time
        v0 = vcnt;
        tick_en = 1'b0;
        rxd = 1'b0;
        repeat (200) @(posedge clk);
        #1 rxd = 1'b1;
        repeat (4) @(posedge clk);
        tick_en = 1'b1;
        wait_ticks(100);
        chk("R10", "no frame without ticks", vcnt - v0, 0);
        send_frame("R10 frame after pause", 0, 1'b0, 8'h1B, 1'b0, 1'b1, 8'h00, 1'b0, 8'h00);

        for (int k = 0; k < 40; k++) begin
            logic sv;
            sv = ($urandom % 8) != 0;
            send_frame("R3 R4 R5 random", int'($urandom % 4), 1'($urandom), 8'($urandom),
                       1'($urandom), sv, 8'h00, 1'b1, 8'h00);
            rxd = 1'b1;
            if (!sv) wait_ticks(2);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule